// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block arbitrates sixteen prioritized event levels for a small processor core. Level 0 ranks highest. The levels have fixed roles:

| Level | Role |
|---|---|
| 0 | debug (emulation) |
| 1 | reset |
| 2 | non-maskable interrupt |
| 3 | exception |
| 4 | global-disable flag |
| 5 to 15 | general interrupts |

The block keeps three 16-bit registers: a latch of requested events, an enable mask and an in-service (pending) set. Each cycle it decides whether a requested event preempts the level being serviced. When one does, it redirects the program counter to that level's handler vector and saves a return address in one of four return registers. There is one register for each return class: debug, NMI, exception and interrupt.

The core leaves a handler by issuing a return command with a class. The block checks that the class matches the level being serviced. A valid return restores the saved address and retires the level. An invalid one raises a one-cycle illegal-return flag and changes nothing.

Two further mechanisms guard the design:
- A nested entry, where a level re-enters itself, is marked in bit 0 of the saved address, and that level is then not retired on return.
- A fault-class request that cannot preempt raises a sticky double-fault flag.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the latch, the mask and the override mask are zero, and only pending bit 1 is set, so `cur_level` reads 1. `pc_load`, `ill_ret` and `dbl_fault` are 0.
- R2: `cur_level` is the lowest-numbered set pending bit, ignoring bit 4. When no such bit is set it reads 16, which stands for user mode and ranks below all levels.
- R3: A general level (5 to 15) is entered only when all three of these hold:
  - its mask bit is set;
  - pending bit 4 is clear, or the core is in user mode;
  - it is numerically below `cur_level`, or it equals `cur_level` while `self_nest` is 1.
- R4: On entry, the level's pending bit is set and its latch bit is cleared. If the level is 5 or above, pending bit 4 is also set. In the next cycle `pc_load` pulses and `pc_new` holds the level's vector, which is word k of `vec_table` (bits k*AW+AW-1 down to k*AW).
- R5: Levels 0 and 1 are always entered. Levels 2 and 3 are entered when they rank above `cur_level`. Otherwise the request is dropped from the latch and `dbl_fault` is set and stays set until reset. Mask bits 0 to 3 have no effect.
- R6: On exception entry, the saved exception return address depends on `exc_cause`. It is `cur_pc` when `exc_cause` is 0x20 or higher, and `next_pc` otherwise. Debug and NMI entries save `cur_pc`.
- R7: On general entry, the saved interrupt return address is `cur_pc` with bit 0 set exactly when the entry is nested at the current level.
- R8: `ret_class` is encoded as 0 debug, 1 NMI, 2 exception and 3 interrupt. Each class is valid only at certain levels:
  - debug only at level 0;
  - NMI only at level 2;
  - exception only at level 3;
  - interrupt at any level except 0, 2, 3 and user mode.

  An invalid return pulses `ill_ret` for one cycle and has no other effect.
- R9: A valid return loads `pc_new` with the class's saved address with bit 0 cleared. It retires the target level only if that bit 0 was 0. It clears pending bit 4 when the target level is 1 or 5 and above.
- R10: The override mask keeps only bits 15 to 7 of what is written. A level whose override bit is set enters at the level-1 vector instead of its own.
- R11: A return command takes precedence over any entry decision in the same cycle. A request arriving in that cycle stays latched and is decided in a later cycle.
- R12: A pulse on `irq_reenable` clears pending bit 4, which allows nesting inside a general handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 16 | Event request strobes, one per level (bit 4 ignored) |
| ret_valid | input | 1 | Return command strobe |
| ret_class | input | 2 | Return class: 0 debug, 1 NMI, 2 exception, 3 interrupt |
| cur_pc | input | AW | Address of the instruction about to run |
| next_pc | input | AW | Address of the following instruction |
| exc_cause | input | CW | Exception cause code |
| vec_table | input | 16*AW | Handler vectors, word k for level k |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wd | input | 16 | Enable mask write data |
| ovr_we | input | 1 | Write strobe for the override mask |
| ovr_wd | input | 16 | Override mask write data (bits 6:0 dropped) |
| self_nest | input | 1 | Allows a general level to re-enter itself |
| irq_reenable | input | 1 | Clears the global-disable flag |
| pc_load | output | 1 | One-cycle strobe: `pc_new` is valid |
| pc_new | output | AW | Redirected program counter |
| cur_level | output | 5 | Level in service, 16 for user mode |
| dbl_fault | output | 1 | Sticky double-fault flag |
| ill_ret | output | 1 | One-cycle illegal-return flag |

## Verification
The assertions assume that the return class and the request strobes are clean, known values in every cycle after reset. They also assume that `ret_valid` is low during reset, so that every `pc_load` seen at a general level can be traced back to either an entry or a return. The stimulus changes every input on the falling edge, holds it for exactly one rising edge, and drives `ret_valid` and the write strobes to zero between commands. It never combines `irq_reenable` with a request in the same cycle. It resets the block once and then walks a single continuous history of entries and returns. Every pending bit therefore arises from earlier stimulus and never from a forced state.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int NLVL      = 16;
    localparam int LW        = 5;
    localparam logic [LW-1:0] LVL_USER = 5'd16;
    localparam logic [LW-1:0] LVL_DBG  = 5'd0;
    localparam logic [LW-1:0] LVL_RST  = 5'd1;
    localparam logic [LW-1:0] LVL_NMI  = 5'd2;
    localparam logic [LW-1:0] LVL_EXC  = 5'd3;
    localparam logic [LW-1:0] LVL_GDIS = 5'd4;
    localparam logic [LW-1:0] LVL_GEN  = 5'd5;
    localparam logic [NLVL-1:0] UNMASKABLE = 16'h000F;
    localparam logic [NLVL-1:0] GDIS_BIT   = 16'h0010;
    localparam logic [NLVL-1:0] OVR_KEEP   = 16'hFF80;
    localparam logic [NLVL-1:0] PEND_RESET = 16'h0002;

    typedef enum logic [1:0] {
        RC_DBG = 2'd0,
        RC_NMI = 2'd1,
        RC_EXC = 2'd2,
        RC_INT = 2'd3
    } ret_cls_e;

    typedef struct packed {
        logic            take;
        logic            dbl;
        logic            nest;
        logic [LW-1:0]   lvl;
    } pick_t;

    typedef struct packed {
        logic            ok;
        ret_cls_e        cls;
        logic [LW-1:0]   tgt;
    } retchk_t;

    function automatic logic [LW-1:0] first_set(input logic [NLVL-1:0] v);
        logic [LW-1:0] r;
        r = LVL_USER;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) r = LW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import evt_pkg::*;
(
    input  logic [NLVL-1:0] req_vec,
    input  logic [NLVL-1:0] mask,
    input  logic [NLVL-1:0] pend,
    input  logic            self_nest,
    output logic [LW-1:0]   cur,
    output pick_t           pick
);
    logic [NLVL-1:0] cand;
    logic [LW-1:0]   k;
    logic            user_mode;
    logic            gdis;

    always_comb begin
        cur       = first_set(pend & ~GDIS_BIT);
        cand      = req_vec & (mask | UNMASKABLE) & ~GDIS_BIT;
        k         = first_set(cand);
        user_mode = (cur == LVL_USER);
        gdis      = pend[LVL_GDIS[3:0]];
        pick      = '0;
        pick.lvl  = k;
        if (k == LVL_USER) begin
            pick.take = 1'b0;
        end else if (k <= LVL_RST) begin
            pick.take = 1'b1;
        end else if (k <= LVL_EXC) begin
            if (k < cur) pick.take = 1'b1;
            else         pick.dbl  = 1'b1;
        end else if ((!gdis || user_mode) &&
                     ((k < cur) || ((k == cur) && self_nest))) begin
            pick.take = 1'b1;
            pick.nest = (k == cur);
        end
    end
endmodule

// File: rtl/evt_retcheck.sv
module evt_retcheck
    import evt_pkg::*;
(
    input  logic          ret_valid,
    input  logic [1:0]    ret_class,
    input  logic [LW-1:0] cur,
    output retchk_t       chk
);
    always_comb begin
        chk     = '0;
        chk.cls = ret_cls_e'(ret_class);
        unique case (chk.cls)
            RC_DBG: begin chk.tgt = LVL_DBG; chk.ok = (cur == LVL_DBG); end
            RC_NMI: begin chk.tgt = LVL_NMI; chk.ok = (cur == LVL_NMI); end
            RC_EXC: begin chk.tgt = LVL_EXC; chk.ok = (cur == LVL_EXC); end
            default: begin
                chk.tgt = cur;
                chk.ok  = (cur != LVL_DBG) && (cur != LVL_NMI) &&
                          (cur != LVL_EXC) && (cur != LVL_USER);
            end
        endcase
        if (!ret_valid) chk.ok = 1'b0;
    end
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
    import evt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 6,
    parameter int SVC_LIMIT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLVL-1:0]    ev_req,
    input  logic               ret_valid,
    input  logic [1:0]         ret_class,
    input  logic [AW-1:0]      cur_pc,
    input  logic [AW-1:0]      next_pc,
    input  logic [CW-1:0]      exc_cause,
    input  logic [NLVL*AW-1:0] vec_table,
    input  logic               mask_we,
    input  logic [NLVL-1:0]    mask_wd,
    input  logic               ovr_we,
    input  logic [NLVL-1:0]    ovr_wd,
    input  logic               self_nest,
    input  logic               irq_reenable,
    output logic               pc_load,
    output logic [AW-1:0]      pc_new,
    output logic [LW-1:0]      cur_level,
    output logic               dbl_fault,
    output logic               ill_ret
);
    localparam int NCLS = 4;
    localparam logic [CW-1:0] SVC_CAUSE = CW'(SVC_LIMIT);

    logic [NLVL-1:0] latch_q, mask_q, ovr_q, pend_q;
    logic [NLVL-1:0] latch_d, pend_d, req_vec;
    logic [AW-1:0]   rreg_q [NCLS];
    logic [AW-1:0]   rreg_d [NCLS];
    logic [AW-1:0]   pc_d, rsel;
    logic            load_d, ill_d, dbl_d;
    logic [LW-1:0]   cur;
    pick_t           pick;
    retchk_t         chk;

    assign req_vec = latch_q | (ev_req & ~GDIS_BIT);

    evt_arbiter u_arb (
        .req_vec   (req_vec),
        .mask      (mask_q),
        .pend      (pend_q),
        .self_nest (self_nest),
        .cur       (cur),
        .pick      (pick)
    );

    evt_retcheck u_ret (
        .ret_valid (ret_valid),
        .ret_class (ret_class),
        .cur       (cur),
        .chk       (chk)
    );

    always_comb begin
        latch_d = req_vec;
        pend_d  = pend_q;
        pc_d    = pc_new;
        load_d  = 1'b0;
        ill_d   = 1'b0;
        dbl_d   = dbl_fault;
        rsel    = rreg_q[chk.cls];
        for (int c = 0; c < NCLS; c++) rreg_d[c] = rreg_q[c];
        if (irq_reenable) pend_d[LVL_GDIS[3:0]] = 1'b0;
        if (ret_valid) begin
            if (!chk.ok) begin
                ill_d = 1'b1;
            end else begin
                load_d = 1'b1;
                pc_d   = {rsel[AW-1:1], 1'b0};
                if (!rsel[0]) pend_d[chk.tgt[3:0]] = 1'b0;
                if (chk.tgt >= LVL_GEN || chk.tgt == LVL_RST)
                    pend_d[LVL_GDIS[3:0]] = 1'b0;
            end
        end else if (pick.take) begin
            load_d = 1'b1;
            pend_d[pick.lvl[3:0]]  = 1'b1;
            latch_d[pick.lvl[3:0]] = 1'b0;
            pc_d = ovr_q[pick.lvl[3:0]] ? vec_table[LVL_RST*AW +: AW]
                                        : vec_table[pick.lvl[3:0]*AW +: AW];
            if (pick.lvl >= LVL_GEN) begin
                pend_d[LVL_GDIS[3:0]] = 1'b1;
                rreg_d[RC_INT] = {cur_pc[AW-1:1], cur_pc[0] | pick.nest};
            end else if (pick.lvl == LVL_DBG) begin
                rreg_d[RC_DBG] = cur_pc;
            end else if (pick.lvl == LVL_NMI) begin
                rreg_d[RC_NMI] = cur_pc;
            end else if (pick.lvl == LVL_EXC) begin
                rreg_d[RC_EXC] = (exc_cause >= SVC_CAUSE) ? cur_pc : next_pc;
            end
        end else if (pick.dbl) begin
            dbl_d = 1'b1;
            latch_d[pick.lvl[3:0]] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            mask_q    <= '0;
            ovr_q     <= '0;
            pend_q    <= PEND_RESET;
            pc_load   <= 1'b0;
            pc_new    <= '0;
            ill_ret   <= 1'b0;
            dbl_fault <= 1'b0;
            for (int c = 0; c < NCLS; c++) rreg_q[c] <= '0;
        end else begin
            latch_q   <= latch_d;
            pend_q    <= pend_d;
            pc_load   <= load_d;
            pc_new    <= pc_d;
            ill_ret   <= ill_d;
            dbl_fault <= dbl_d;
            for (int c = 0; c < NCLS; c++) rreg_q[c] <= rreg_d[c];
            if (mask_we) mask_q <= mask_wd;
            if (ovr_we)  ovr_q  <= ovr_wd & OVR_KEEP;
        end
    end

    assign cur_level = cur;

    p_reset_pending_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == PEND_RESET && !pc_load));

    p_gdis_on_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (pc_load && cur_level >= LVL_GEN && cur_level != LVL_USER && !$past(ret_valid))
        |-> pend_q[LVL_GDIS[3:0]]);

    p_dbl_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        $past(dbl_fault) |-> dbl_fault);

    p_illegal_no_load_r8: assert property (@(posedge clk) disable iff (rst)
        ill_ret |-> (!pc_load && $stable(pend_q)));

    p_ovr_low_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ovr_q[6:0] == 7'd0);
endmodule

// File: tb/evt_nest_ctrl_test.sv
module evt_nest_ctrl_test;
    localparam int AW = 32;
    localparam int CW = 6;
    localparam int NL = 16;

    typedef struct {
        logic        load;
        logic [31:0] pc;
        logic [4:0]  lvl;
        logic        ill;
        logic        df;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NL-1:0]    ev_req = '0;
    logic             ret_valid = 1'b0;
    logic [1:0]       ret_class = '0;
    logic [AW-1:0]    cur_pc = '0, next_pc = '0;
    logic [CW-1:0]    exc_cause = '0;
    logic [NL*AW-1:0] vec_table;
    logic             mask_we = 1'b0, ovr_we = 1'b0;
    logic [NL-1:0]    mask_wd = '0, ovr_wd = '0;
    logic             self_nest = 1'b0, irq_reenable = 1'b0;
    logic             pc_load, dbl_fault, ill_ret;
    logic [AW-1:0]    pc_new;
    logic [4:0]       cur_level;

    int n_chk = 0, n_bad = 0;
    item_t q[$];
    logic  exp_df = 1'b0;
    logic  m_we = 0, o_we = 0, reen = 0, sn = 0;
    logic [NL-1:0] m_wd = '0, o_wd = '0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_nest_ctrl #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .ev_req(ev_req), .ret_valid(ret_valid),
        .ret_class(ret_class), .cur_pc(cur_pc), .next_pc(next_pc),
        .exc_cause(exc_cause), .vec_table(vec_table), .mask_we(mask_we),
        .mask_wd(mask_wd), .ovr_we(ovr_we), .ovr_wd(ovr_wd),
        .self_nest(self_nest), .irq_reenable(irq_reenable),
        .pc_load(pc_load), .pc_new(pc_new), .cur_level(cur_level),
        .dbl_fault(dbl_fault), .ill_ret(ill_ret)
    );

    always_comb for (int k = 0; k < NL; k++) vec_table[k*AW +: AW] = 32'h1000 + k * 32'h100;

    task automatic step(input logic [NL-1:0] req, input logic rv, input logic [1:0] rc,
                        input logic [31:0] cpc, input logic [31:0] npc, input logic [5:0] cs,
                        input logic el, input logic [31:0] epc, input logic [4:0] elv,
                        input logic eill, input string tag);
        item_t it;
        @(negedge clk);
        ev_req = req; ret_valid = rv; ret_class = rc; cur_pc = cpc; next_pc = npc;
        exc_cause = cs; mask_we = m_we; mask_wd = m_wd; ovr_we = o_we; ovr_wd = o_wd;
        self_nest = sn; irq_reenable = reen;
        m_we = 0; o_we = 0; reen = 0;
        it.load = el; it.pc = epc; it.lvl = elv; it.ill = eill; it.df = exp_df; it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (pc_load !== it.load || (it.load && pc_new !== it.pc) ||
                    cur_level !== it.lvl || ill_ret !== it.ill || dbl_fault !== it.df) begin
                    n_bad++;
                    $display("FAIL %s: load=%0b pc=%h lvl=%0d ill=%0b df=%0b expected load=%0b pc=%h lvl=%0d ill=%0b df=%0b",
                             it.tag, pc_load, pc_new, cur_level, ill_ret, dbl_fault,
                             it.load, it.pc, it.lvl, it.ill, it.df);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (cur_level !== 5'd1 || pc_load !== 1'b0 || ill_ret !== 1'b0 || dbl_fault !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: lvl=%0d load=%0b ill=%0b df=%0b expected lvl=1 load=0 ill=0 df=0",
                     cur_level, pc_load, ill_ret, dbl_fault);
        end
        // R9 R8: interrupt-class return from reset level goes to user mode
        step(16'h0, 1, 2'd3, 0, 0, 0, 1, 32'h0, 5'd16, 0, "R9 return from reset");
        m_we = 1; m_wd = 16'hFFE0;
        step(16'h0, 0, 0, 0, 0, 0, 0, 0, 5'd16, 0, "R2 user mode idle");
        step(16'h0400, 0, 0, 32'h200, 0, 0, 1, 32'h1A00, 5'd10, 0, "R4 entry level 10");
        step(16'h1000, 0, 0, 32'h210, 0, 0, 0, 0, 5'd10, 0, "R3 lower priority held");
        step(16'h0080, 0, 0, 32'h220, 0, 0, 0, 0, 5'd10, 0, "R3 global disable blocks");
        step(16'h0, 1, 2'd3, 0, 0, 0, 1, 32'h200, 5'd16, 0, "R9 interrupt return");
        step(16'h0, 0, 0, 32'h300, 0, 0, 1, 32'h1700, 5'd7, 0, "R2 latched level 7 wins");
        step(16'h0, 1, 2'd1, 0, 0, 0, 0, 0, 5'd7, 1, "R8 NMI return at 7 illegal");
        step(16'h0008, 0, 0, 32'h400, 32'h402, 6'h21, 1, 32'h1300, 5'd3, 0, "R5 exception entry");
        step(16'h0, 1, 2'd2, 0, 0, 0, 1, 32'h400, 5'd7, 0, "R6 cause>=0x20 faulting pc");
        step(16'h0008, 0, 0, 32'h500, 32'h504, 6'h05, 1, 32'h1300, 5'd3, 0, "R5 exception entry 2");
        step(16'h0, 1, 2'd2, 0, 0, 0, 1, 32'h504, 5'd7, 0, "R6 cause<0x20 next pc");
        step(16'h0, 1, 2'd3, 0, 0, 0, 1, 32'h300, 5'd16, 0, "R9 return level 7");
        step(16'h0, 0, 0, 32'h340, 0, 0, 1, 32'h1C00, 5'd12, 0, "R4 entry level 12");
        reen = 1;
        step(16'h0, 0, 0, 32'h350, 0, 0, 0, 0, 5'd12, 0, "R12 reenable");
        sn = 0;
        step(16'h1000, 0, 0, 32'h360, 0, 0, 0, 0, 5'd12, 0, "R3 same level no self-nest");
        sn = 1;
        step(16'h0, 0, 0, 32'h600, 0, 0, 1, 32'h1C00, 5'd12, 0, "R12 R3 self-nested entry");
        step(16'h0, 1, 2'd3, 0, 0, 0, 1, 32'h600, 5'd12, 0, "R7 nested return keeps level");
        sn = 0; o_we = 1; o_wd = 16'hFFFF;
        step(16'h0, 0, 0, 32'h650, 0, 0, 0, 0, 5'd12, 0, "R10 override write");
        step(16'h0100, 0, 0, 32'h700, 0, 0, 1, 32'h1100, 5'd8, 0, "R10 override uses reset vector");
        step(16'h0004, 0, 0, 32'h780, 0, 0, 1, 32'h1200, 5'd2, 0, "R10 NMI not overridden");
        step(16'h0, 1, 2'd1, 0, 0, 0, 1, 32'h780, 5'd8, 0, "R9 NMI return");
        step(16'h0, 1, 2'd0, 0, 0, 0, 0, 0, 5'd8, 1, "R8 debug return at 8 illegal");
        m_we = 1; m_wd = 16'hFF80;
        step(16'h0, 0, 0, 0, 0, 0, 0, 0, 5'd8, 0, "R3 mask write");
        reen = 1;
        step(16'h0, 0, 0, 0, 0, 0, 0, 0, 5'd8, 0, "R12 reenable");
        step(16'h0040, 0, 0, 32'h7F0, 0, 0, 0, 0, 5'd8, 0, "R3 masked level 6 ignored");
        m_we = 1; m_wd = 16'hFFE0;
        step(16'h0, 0, 0, 32'h7F8, 0, 0, 0, 0, 5'd8, 0, "R3 mask write not yet active");
        step(16'h0, 0, 0, 32'h800, 0, 0, 1, 32'h1600, 5'd6, 0, "R10 level 6 own vector");
        step(16'h0008, 0, 0, 32'h880, 32'h884, 6'h30, 1, 32'h1300, 5'd3, 0, "R5 exception at 6");
        exp_df = 1'b1;
        step(16'h0008, 0, 0, 32'h890, 32'h894, 6'h30, 0, 0, 5'd3, 0, "R5 double fault");
        step(16'h0001, 0, 0, 32'h900, 0, 0, 1, 32'h1000, 5'd0, 0, "R5 debug always taken");
        step(16'h0001, 1, 2'd0, 0, 0, 0, 1, 32'h900, 5'd3, 0, "R11 return beats request");
        step(16'h0, 0, 0, 32'hA00, 0, 0, 1, 32'h1000, 5'd0, 0, "R11 latched debug taken");
        step(16'h0, 1, 2'd3, 0, 0, 0, 0, 0, 5'd0, 1, "R8 interrupt return at 0 illegal");
        @(negedge clk);
        ret_valid = 0; ev_req = '0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule